// File: doc/BRIEF.md
# Parallel Step-Attenuator Control with Power-Up Policy

This block drives the 6-bit attenuation code of a step attenuator (0.5 dB per step, code 63 is the largest attenuation) from six parallel control lines. A select input chooses whether the output code comes from this parallel path or from an external serial path, which reaches the block only as a 6-bit code input to the output multiplexer.

The parallel path has two policies. The level of the latch-enable input during power-up reset picks one of them, and that choice holds until the next reset. In the latched policy, the code stays at maximum attenuation after reset. After that, a rising edge of latch-enable loads the control lines. In the direct policy, the code stays at its reset value while a fixed number of microsecond ticks is counted. At the end of that count it takes the control lines, or a fixed 28 dB code if a strap-sense input reports the lines as undriven. From then on it follows the lines every cycle.

Top module: `atten_par_ctrl`

## Requirements
- R1: While `mode_ser_i` is 1, `atten_o` equals `ser_state_i` in the same cycle.
- R2: While `mode_ser_i` is 0, `atten_o` shows the internal parallel code in the same cycle.
- R3: The value of `le_i` at the last clock edge with `rst_i` high selects the policy: 1 gives direct and 0 gives latched. Later changes of `le_i` do not alter the policy until the next reset.
- R4: A clock edge with `rst_i` high sets the parallel code to 63 under either policy.
- R5: Latched policy: at an edge where `le_i` is 1 and was 0 at the previous edge, the parallel code takes `d_i`, visible after that edge.
- R6: Latched policy: at any other edge the parallel code is unchanged, whatever `d_i`, `us_tick_i` or a steady-high `le_i` do.
- R7: Direct policy: the parallel code stays 63 until the SETTLE_US-th edge after reset at which `us_tick_i` is 1. At that edge it loads `d_i`.
- R8: Direct policy, after settling: at every edge the parallel code takes `d_i`, visible one cycle later.
- R9: Direct policy: if `pins_open_i` is 1 at the settling edge, the code loaded is 56 (28 dB) instead of `d_i`. Outside that edge `pins_open_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high power-up reset |
| mode_ser_i | input | 1 | 1 selects the serial code, 0 the parallel code |
| le_i | input | 1 | Latch-enable; its level in reset chooses the policy |
| d_i | input | 6 | Parallel control lines, attenuation code |
| pins_open_i | input | 1 | Strap sense: 1 when the control lines are undriven |
| us_tick_i | input | 1 | One-cycle pulse each microsecond |
| ser_state_i | input | 6 | Code from the serial path |
| atten_o | output | 6 | Attenuation code to the attenuator |

## Verification
The output multiplexer is combinational, so a serial code or a mode change is due in the same cycle. Every change to the parallel code lands exactly one edge after the inputs that cause it: a latch-enable rise, a direct-mode line change, or the final settling tick. The bench drives inputs on the falling edge. It compares `atten_o` at the next falling edge against a model advanced on each rising edge. Each comparison therefore lands after exactly one register stage, or after none for the multiplexer.

// File: rtl/atten_pkg.sv
package atten_pkg;

    localparam int unsigned CODE_W = 6;

    typedef enum logic {
        POL_LATCHED = 1'b0,
        POL_DIRECT  = 1'b1
    } par_policy_e;

    typedef struct packed {
        par_policy_e policy;
        logic        le_prev;
    } ctrl_state_t;

    function automatic logic [CODE_W-1:0] max_code();
        return {CODE_W{1'b1}};
    endfunction

    function automatic logic [CODE_W-1:0] half_db_to_code(input int unsigned half_db);
        return CODE_W'(half_db);
    endfunction

endpackage

// File: rtl/atten_policy.sv
module atten_policy
    import atten_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        le_i,
    output par_policy_e policy_o,
    output logic        le_rise_o
);
    ctrl_state_t st_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.policy <= le_i ? POL_DIRECT : POL_LATCHED;
        end
        st_q.le_prev <= le_i;
    end

    assign policy_o  = st_q.policy;
    assign le_rise_o = (st_q.policy == POL_LATCHED) && le_i && !st_q.le_prev;
endmodule

// File: rtl/atten_settle.sv
module atten_settle #(
    parameter int unsigned SETTLE_US = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    output logic busy_o,
    output logic done_o
);
    generate
        if (SETTLE_US == 0) begin : g_none
            assign busy_o = 1'b0;
            assign done_o = 1'b0;
        end else begin : g_count
            localparam int unsigned CW = (SETTLE_US > 1) ? $clog2(SETTLE_US) : 1;
            localparam logic [CW-1:0] LAST = CW'(SETTLE_US - 1);
            logic [CW-1:0] cnt_q;
            logic          busy_q;
            logic          last_tick;

            assign last_tick = busy_q && tick_i && (cnt_q == LAST);

            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    cnt_q  <= '0;
                    busy_q <= 1'b1;
                end else if (busy_q && tick_i) begin
                    if (cnt_q == LAST) begin
                        busy_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end

            assign busy_o = busy_q;
            assign done_o = last_tick;
        end
    endgenerate
endmodule

// File: rtl/atten_par_state.sv
module atten_par_state
    import atten_pkg::*;
#(
    parameter int unsigned W         = CODE_W,
    parameter int unsigned OPEN_CODE = 56
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  par_policy_e  policy_i,
    input  logic         le_rise_i,
    input  logic         settle_busy_i,
    input  logic         settle_done_i,
    input  logic         pins_open_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] code_o
);
    localparam logic [W-1:0] OPEN_VAL = W'(OPEN_CODE);
    logic [W-1:0] code_q;
    logic [W-1:0] code_d;

    always_comb begin
        code_d = code_q;
        if (policy_i == POL_DIRECT) begin
            if (settle_done_i) begin
                code_d = pins_open_i ? OPEN_VAL : d_i;
            end else if (!settle_busy_i) begin
                code_d = d_i;
            end
        end else if (le_rise_i) begin
            code_d = d_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            code_q <= {W{1'b1}};
        end else begin
            code_q <= code_d;
        end
    end

    assign code_o = code_q;
endmodule

// File: rtl/atten_par_ctrl.sv
module atten_par_ctrl
    import atten_pkg::*;
#(
    parameter int unsigned ATTEN_W   = CODE_W,
    parameter int unsigned SETTLE_US = 4,
    parameter int unsigned OPEN_CODE = 56
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               mode_ser_i,
    input  logic               le_i,
    input  logic [ATTEN_W-1:0] d_i,
    input  logic               pins_open_i,
    input  logic               us_tick_i,
    input  logic [ATTEN_W-1:0] ser_state_i,
    output logic [ATTEN_W-1:0] atten_o
);
    par_policy_e        policy;
    logic               policy_direct;
    logic               le_rise;
    logic               settle_busy;
    logic               settle_done;
    logic [ATTEN_W-1:0] par_state;

    atten_policy u_policy (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .le_i      (le_i),
        .policy_o  (policy),
        .le_rise_o (le_rise)
    );

    assign policy_direct = (policy == POL_DIRECT);

    atten_settle #(.SETTLE_US(SETTLE_US)) u_settle (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (us_tick_i),
        .busy_o (settle_busy),
        .done_o (settle_done)
    );

    atten_par_state #(.W(ATTEN_W), .OPEN_CODE(OPEN_CODE)) u_state (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .policy_i      (policy),
        .le_rise_i     (le_rise),
        .settle_busy_i (settle_busy),
        .settle_done_i (settle_done),
        .pins_open_i   (pins_open_i),
        .d_i           (d_i),
        .code_o        (par_state)
    );

    assign atten_o = mode_ser_i ? ser_state_i : par_state;
endmodule

// File: rtl/atten_par_ctrl_chk.sv
module atten_par_ctrl_chk #(
    parameter int unsigned ATTEN_W   = 6,
    parameter int unsigned OPEN_CODE = 56
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               le_i,
    input logic               pins_open_i,
    input logic [ATTEN_W-1:0] d_i,
    input logic               policy_direct,
    input logic               settle_busy,
    input logic               settle_done,
    input logic [ATTEN_W-1:0] par_state
);
    localparam logic [ATTEN_W-1:0] MAXC  = {ATTEN_W{1'b1}};
    localparam logic [ATTEN_W-1:0] OPENC = ATTEN_W'(OPEN_CODE);

    a_r3_policy_fixed: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> $stable(policy_direct));

    a_r4_reset_max: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> par_state == MAXC);

    a_r5_rise_loads: assert property (@(posedge clk_i) disable iff (rst_i)
        (!policy_direct && $rose(le_i)) |=> par_state == $past(d_i));

    a_r6_latched_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        (!policy_direct && !$rose(le_i)) |=> $stable(par_state));

    a_r7_settle_max: assert property (@(posedge clk_i) disable iff (rst_i)
        (policy_direct && settle_busy) |-> par_state == MAXC);

    a_r8_direct_follows: assert property (@(posedge clk_i) disable iff (rst_i)
        (policy_direct && !settle_busy) |=> par_state == $past(d_i));

    a_r9_open_default: assert property (@(posedge clk_i) disable iff (rst_i)
        (policy_direct && settle_done && pins_open_i) |=> par_state == OPENC);
endmodule

bind atten_par_ctrl atten_par_ctrl_chk #(.ATTEN_W(ATTEN_W), .OPEN_CODE(OPEN_CODE)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .le_i          (le_i),
    .pins_open_i   (pins_open_i),
    .d_i           (d_i),
    .policy_direct (policy_direct),
    .settle_busy   (settle_busy),
    .settle_done   (settle_done),
    .par_state     (par_state)
);

// File: tb/atten_par_ctrl_tb_top.sv
module atten_par_ctrl_tb_top;
    localparam int unsigned W      = 6;
    localparam int unsigned SETTLE = 4;
    localparam logic [W-1:0] MAXC  = 6'd63;
    localparam logic [W-1:0] OPENC = 6'd56;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_ser = 1'b0;
    logic         le = 1'b0;
    logic [W-1:0] d = '0;
    logic         pins_open = 1'b0;
    logic         tick = 1'b0;
    logic [W-1:0] ser = '0;
    logic [W-1:0] atten;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    atten_par_ctrl #(.ATTEN_W(W), .SETTLE_US(SETTLE), .OPEN_CODE(56)) dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .mode_ser_i  (mode_ser),
        .le_i        (le),
        .d_i         (d),
        .pins_open_i (pins_open),
        .us_tick_i   (tick),
        .ser_state_i (ser),
        .atten_o     (atten)
    );

    // Reference model built from the requirements.
    logic         m_dir;
    logic         m_busy;
    int           m_cnt;
    logic         m_le;
    logic [W-1:0] m_par;
    string        m_tag = "R4";
    bit           m_valid = 1'b0;

    function automatic logic [W-1:0] settle_code(input logic open, input logic [W-1:0] lines);
        return open ? OPENC : lines;
    endfunction

    always @(posedge clk) begin
        m_valid <= 1'b1;
        m_le    <= le;
        if (rst) begin
            m_dir  <= le;
            m_par  <= MAXC;
            m_busy <= 1'b1;
            m_cnt  <= 0;
            m_tag  <= "R4";
        end else if (m_dir) begin
            if (m_busy) begin
                if (tick && m_cnt == SETTLE - 1) begin
                    m_busy <= 1'b0;
                    m_par  <= settle_code(pins_open, d);
                    m_tag  <= pins_open ? "R9" : "R7";
                end else begin
                    if (tick) m_cnt <= m_cnt + 1;
                    m_tag <= "R7";
                end
            end else begin
                m_par <= d;
                m_tag <= le ? "R8" : "R3 R8";
            end
        end else if (le && !m_le) begin
            m_par <= d;
            m_tag <= "R5";
        end else begin
            m_tag <= "R6";
        end
    end

    task automatic cyc();
        logic [W-1:0] exp;
        string tag;
        @(negedge clk);
        if (m_valid) begin
            exp = mode_ser ? ser : m_par;
            tag = mode_ser ? "R1" : {"R2 ", m_tag};
            n_chk++;
            if (atten !== exp) begin
                n_bad++;
                $display("FAIL %s: atten_o=%0d expected %0d at %0t", tag, atten, exp, $time);
            end
        end
    endtask

    task automatic do_reset(input logic le_lvl, input logic open);
        rst = 1'b1; le = le_lvl; pins_open = open; tick = 1'b0; mode_ser = 1'b0;
        repeat (3) cyc();
        rst = 1'b0;
    endtask

    task automatic rand_run(input int n, input int tick_gap, input bit le_rand);
        for (int i = 0; i < n; i++) begin
            cyc();
            mode_ser = ($urandom % 4) == 0;
            ser      = W'($urandom);
            d        = W'($urandom);
            tick     = tick_gap != 0 && (i % tick_gap) == 0;
            if (le_rand && ($urandom % 5) == 0) le = ~le;
            pins_open = ($urandom % 3) == 0;
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_a770));
        // Latched policy: reset default, directed pulses, steady-high LE.
        d = 6'd9;
        do_reset(1'b0, 1'b0);
        cyc();                       // R4: 63 after reset
        d = 6'd17; cyc(); cyc();     // R6: lines change, no load
        le = 1'b1; cyc();            // R5: rise captures 17
        d = 6'd40; cyc(); cyc();     // R6: LE held high, no reload
        le = 1'b0; cyc();
        le = 1'b1; d = 6'd0; cyc();  // R5: capture 0
        le = 1'b0; cyc();
        mode_ser = 1'b1; ser = 6'd33; cyc(); // R1
        mode_ser = 1'b0; cyc();
        rand_run(250, 3, 1'b1);
        // Direct policy with driven lines.
        d = 6'd21;
        do_reset(1'b1, 1'b0);
        d = 6'd21;
        for (int i = 0; i < 24; i++) begin
            cyc();
            tick = (i % 5) == 4;     // R7: 63 until 4th tick
        end
        tick = 1'b0;
        le = 1'b0; d = 6'd2; cyc(); cyc(); // R3: LE low, still direct
        rand_run(200, 7, 1'b1);
        // Direct policy with undriven lines.
        d = 6'd5;
        do_reset(1'b1, 1'b1);
        for (int i = 0; i < 16; i++) begin
            cyc();
            tick = (i % 3) == 0;
        end
        tick = 1'b0; pins_open = 1'b1; cyc(); // R9 after settle, open ignored
        rand_run(120, 2, 1'b1);
        // Back to latched with ticks that must not matter.
        do_reset(1'b0, 1'b0);
        rand_run(200, 1, 1'b1);
        cyc();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule